// File: doc/BRIEF.md
# Write-Through Store Buffer with Read Forwarding

This block is a small in-order queue that sits between a write-through cache and a slow memory. Each processor store is written into the cache and, in the same cycle, offered to this buffer. The buffer holds the address, the data word and a byte mask for each store. A drain port on the memory side hands the entries to the memory controller one at a time, oldest first, under a valid/ready handshake.

Stores can arrive faster than the memory retires them. When that happens the buffer fills, and the processor-side ready signal drops so that the processor stalls. If the memory takes an entry in the same cycle, a new store is still accepted. The buffer also serves a lookup port that the processor's read path uses. When the read address equals the address of an entry still waiting in the buffer, the block flags a hit and returns that entry's data and mask. This prevents the read from seeing stale memory contents. If several waiting entries carry the same address, the most recent one wins.

Top module: `wt_store_buf`

## Requirements
- R1: While reset is held and in the first cycle after it is released: empty is 1, full is 0, drain valid is 0, store ready is 1 and the lookup hit is 0.
- R2: A store is taken on a rising edge where both store valid and store ready are high, and its address, data and mask are kept together as one entry.
- R3: While the buffer holds any entry, drain valid is 1 and the drain port shows the oldest entry. An entry leaves on an edge where drain valid and drain ready are both high, and entries leave in the order they were taken.
- R4: While drain valid is 1 and drain ready is 0, the drain outputs stay unchanged from cycle to cycle.
- R5: With no draining, DEPTH stores (4 by default) make full high. Store ready is then low whenever drain ready is low, and a store offered at that time is not taken.
- R6: When the buffer is full and drain ready is high, store ready is high. A store and a drain on the same edge both complete, full stays high and no entry is lost.
- R7: The lookup is combinational. The hit is 1 when the lookup address equals the full address of a waiting entry, and the hit data and mask are that entry's. A store becomes visible to the lookup only from the cycle after it is taken.
- R8: When several waiting entries match the lookup address, the data and mask of the most recently taken one are returned.
- R9: The hit is 0 when no waiting entry matches, including an entry that has already been drained.
- R10: A store and a drain on the same edge while the buffer is partly filled leave the occupancy unchanged: neither empty nor full changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Processor offers a store |
| st_ready | output | 1 | Buffer can take a store this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data word |
| st_be | input | DATA_W/8 | Store byte mask |
| rd_addr | input | ADDR_W | Lookup address from the read path |
| fwd_hit | output | 1 | A waiting entry matches rd_addr |
| fwd_data | output | DATA_W | Data of the youngest matching entry |
| fwd_be | output | DATA_W/8 | Mask of the youngest matching entry |
| mem_valid | output | 1 | Drain port holds an entry |
| mem_ready | input | 1 | Memory takes the entry this cycle |
| mem_addr | output | ADDR_W | Address of the oldest entry |
| mem_data | output | DATA_W | Data of the oldest entry |
| mem_be | output | DATA_W/8 | Mask of the oldest entry |
| full | output | 1 | All DEPTH slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
Two events can land on the same edge: a store being accepted and the oldest entry being drained. The critical case is a full buffer, where the slot being freed is the slot being written. The bench fills the buffer while holding drain ready low. It then raises store valid and drain ready in the same cycle, and checks that ready is granted, that full stays set, and that draining afterwards returns every original entry plus the new one in order. The same pairing is repeated on a partly filled buffer, where occupancy must not change. A third case applies a lookup and a store to the same address in the same cycle, and the hit must appear only one cycle later.

// File: rtl/sbuf_pkg.sv
// Shared definitions for the write-through store buffer.
// Assumes nothing beyond standard SystemVerilog.
package sbuf_pkg;
    // Operation decoded from {drain, store} for one clock edge
    typedef enum logic [1:0] {
        SB_IDLE = 2'b00,
        SB_PUSH = 2'b01,
        SB_POP  = 2'b10,
        SB_BOTH = 2'b11
    } sb_op_e;
endpackage

// File: rtl/sbuf_ctrl.sv
// Occupancy and pointer control for the store buffer.
// Keeps write and read pointers plus a count. Derives full/empty, the
// processor-side ready and the accept/retire strobes.
// Assumes DEPTH >= 2.
module sbuf_ctrl
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             mem_ready,
    output logic             st_ready,
    output logic             mem_valid,
    output logic             full,
    output logic             empty,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);
    logic [CNT_W-1:0] count;
    sb_op_e           op;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Flags, handshakes and the decoded operation
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        empty     = (count == '0);
        mem_valid = !empty;
        pop       = mem_valid && mem_ready;
        st_ready  = !full || mem_ready;
        push      = st_valid && st_ready;
        op        = sb_op_e'({pop, push});
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            case (op)
                SB_PUSH: begin
                    wr_ptr <= bump(wr_ptr);
                    count  <= count + 1'b1;
                end
                SB_POP: begin
                    rd_ptr <= bump(rd_ptr);
                    count  <= count - 1'b1;
                end
                SB_BOTH: begin
                    wr_ptr <= bump(wr_ptr);
                    rd_ptr <= bump(rd_ptr);
                end
                default: ;
            endcase
        end
    end

    // R10
    occ_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (count == $past(count)));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !mem_ready) |=> full);

    // R3
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/sbuf_store.sv
// Entry storage for the store buffer.
// One slot per generate iteration. A slot is written at the write
// pointer on accept and marked free at the read pointer on retire. The
// oldest slot is presented at the drain port.
// Assumes the controller never writes a live slot unless it retires it
// on the same edge.
module sbuf_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BE_W-1:0]   in_be,
    output logic [DEPTH-1:0]  slot_vld,
    output logic [ADDR_W-1:0] slot_addr [DEPTH],
    output logic [DATA_W-1:0] slot_data [DEPTH],
    output logic [BE_W-1:0]   slot_be   [DEPTH],
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [BE_W-1:0]   head_be
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic wr_here;
        logic rd_here;
        assign wr_here = push && (wr_ptr == PTR_W'(i));
        assign rd_here = pop  && (rd_ptr == PTR_W'(i));

        // Slot occupancy: a write wins over a retire of the same slot
        always_ff @(posedge clk) begin
            if (!rst_n)       slot_vld[i] <= 1'b0;
            else if (wr_here) slot_vld[i] <= 1'b1;
            else if (rd_here) slot_vld[i] <= 1'b0;
        end

        // Slot payload capture
        always_ff @(posedge clk) begin
            if (wr_here) begin
                slot_addr[i] <= in_addr;
                slot_data[i] <= in_data;
                slot_be[i]   <= in_be;
            end
        end
    end

    // Oldest entry to the drain port
    always_comb begin
        head_addr = slot_addr[rd_ptr];
        head_data = slot_data[rd_ptr];
        head_be   = slot_be[rd_ptr];
    end

    // R6
    slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!slot_vld[wr_ptr] || (pop && (rd_ptr == wr_ptr))));
endmodule

// File: rtl/sbuf_match.sv
// Address-match forwarding for the store buffer.
// Compares every live slot with the lookup address in parallel. It then
// walks the slots from the newest (just behind the write pointer) toward
// the oldest and returns the first match.
// Purely combinational. Assumes slot_vld marks exactly the waiting entries.
module sbuf_match #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DEPTH-1:0]  slot_vld,
    input  logic [ADDR_W-1:0] slot_addr [DEPTH],
    input  logic [DATA_W-1:0] slot_data [DEPTH],
    input  logic [BE_W-1:0]   slot_be   [DEPTH],
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic [BE_W-1:0]   hit_be
);
    logic [DEPTH-1:0] slot_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = slot_vld[i] && (slot_addr[i] == rd_addr);
    end

    // Newest-first priority pick among matching slots
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        hit_be   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PTR_W-1:0] sel;
            sel = PTR_W'((int'(wr_ptr) + DEPTH - 1 - k) % DEPTH);
            if (!hit && slot_hit[sel]) begin
                hit      = 1'b1;
                hit_data = slot_data[sel];
                hit_be   = slot_be[sel];
            end
        end
    end
endmodule

// File: rtl/wt_store_buf.sv
// Write-through store buffer with read forwarding (top level).
// Accepts processor stores into an in-order queue, drains them to memory
// under valid/ready, stalls the processor when full unless a drain frees
// a slot on the same edge, and forwards the youngest matching entry to
// reads. Assumes word-granular addresses (full-address compare).
module wt_store_buf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int BE_W  = DATA_W / 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              fwd_hit,
    output logic [DATA_W-1:0] fwd_data,
    output logic [BE_W-1:0]   fwd_be,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              full,
    output logic              empty
);
    logic             push;
    logic             pop;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [DEPTH-1:0] slot_vld;
    logic [ADDR_W-1:0] slot_addr [DEPTH];
    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [BE_W-1:0]   slot_be   [DEPTH];

    sbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .mem_ready (mem_ready),
        .st_ready  (st_ready),
        .mem_valid (mem_valid),
        .full      (full),
        .empty     (empty),
        .push      (push),
        .pop       (pop),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr)
    );

    sbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .in_addr   (st_addr),
        .in_data   (st_data),
        .in_be     (st_be),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_be   (slot_be),
        .head_addr (mem_addr),
        .head_data (mem_data),
        .head_be   (mem_be)
    );

    sbuf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_match (
        .rd_addr   (rd_addr),
        .wr_ptr    (wr_ptr),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_be   (slot_be),
        .hit       (fwd_hit),
        .hit_data  (fwd_data),
        .hit_be    (fwd_be)
    );

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));

    // R9
    fwd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> !empty);

    // R6
    full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && mem_ready) |-> st_ready);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !mem_valid));
endmodule

// File: tb/tb_wt_store_buf.sv
module tb_wt_store_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic [31:0] rd_addr = '0;
    logic        fwd_hit;
    logic [31:0] fwd_data;
    logic [3:0]  fwd_be;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;
    logic        full;
    logic        empty;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] qa[$];
    logic [31:0] qd[$];
    logic [3:0]  qb[$];

    always #2 clk = ~clk;

    wt_store_buf dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .rd_addr(rd_addr), .fwd_hit(fwd_hit), .fwd_data(fwd_data), .fwd_be(fwd_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .full(full), .empty(empty)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Offer one store that must be accepted
    task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = b;
        #1 chk("R2 store ready", st_ready, 1);
        @(posedge clk);
        #1 st_valid = 1'b0;
        qa.push_back(a); qd.push_back(d); qb.push_back(b);
    endtask

    // Drain one entry and compare it with the oldest expected
    task automatic take();
        @(negedge clk);
        mem_ready = 1'b1;
        #1;
        chk("R3 drain valid", mem_valid, 1);
        chk("R3 drain addr", mem_addr, qa[0]);
        chk("R3 drain data", mem_data, qd[0]);
        chk("R3 drain mask", mem_be, qb[0]);
        @(posedge clk);
        #1 mem_ready = 1'b0;
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
    endtask

    // Lookup and compare the forwarding outputs
    task automatic look(input string tag, input logic [31:0] a, input logic h,
                        input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk({tag, " hit"}, fwd_hit, h);
        if (h) begin
            chk({tag, " data"}, fwd_data, d);
            chk({tag, " mask"}, fwd_be, b);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 empty in reset", empty, 1);
        chk("R1 mem_valid in reset", mem_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 st_ready", st_ready, 1);
        chk("R1 fwd_hit", fwd_hit, 0);
    endtask

    task automatic t_fill_stall();
        for (int i = 0; i < 4; i++) put(32'h1000 + 32'(i*4), 32'hA0 + 32'(i), 4'(i + 1));
        @(negedge clk);
        #1;
        chk("R5 full", full, 1);
        chk("R5 st_ready low", st_ready, 0);
        chk("R3 oldest shown", mem_addr, 32'h1000);
        st_valid = 1'b1; st_addr = 32'hDEAD0; st_data = 32'hBAD; st_be = 4'hF;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk("R5 ready held low", st_ready, 0);
            chk("R4 addr held", mem_addr, 32'h1000);
            chk("R4 data held", mem_data, 32'hA0);
        end
        st_valid = 1'b0;
    endtask

    task automatic t_full_both();
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h2000; st_data = 32'h5555; st_be = 4'h9;
        mem_ready = 1'b1;
        #1;
        chk("R6 ready when full and draining", st_ready, 1);
        chk("R6 head before", mem_addr, 32'h1000);
        @(posedge clk);
        #1 st_valid = 1'b0; mem_ready = 1'b0;
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
        qa.push_back(32'h2000); qd.push_back(32'h5555); qb.push_back(4'h9);
        chk("R6 still full", full, 1);
        for (int i = 0; i < 4; i++) take();
        #1;
        chk("R5 stalled store never entered", empty, 1);
        chk("R5 no extra entry", mem_valid, 0);
    endtask

    task automatic t_forward();
        put(32'h100, 32'h11111111, 4'hF);
        put(32'h200, 32'h22222222, 4'h3);
        put(32'h100, 32'h33333333, 4'hC);
        look("R8 youngest of two", 32'h100, 1, 32'h33333333, 4'hC);
        look("R7 single match", 32'h200, 1, 32'h22222222, 4'h3);
        look("R9 no match", 32'h300, 0, 0, 0);
        take();
        look("R8 after older drained", 32'h100, 1, 32'h33333333, 4'hC);
        take();
        take();
        look("R9 drained entry", 32'h100, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h400; st_data = 32'h4444; st_be = 4'h6;
        rd_addr = 32'h400;
        #1 chk("R7 not visible same cycle", fwd_hit, 0);
        @(posedge clk);
        #1 st_valid = 1'b0;
        qa.push_back(32'h400); qd.push_back(32'h4444); qb.push_back(4'h6);
        chk("R7 visible next cycle", fwd_hit, 1);
        chk("R7 visible data", fwd_data, 32'h4444);
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h500; st_data = 32'h5050; st_be = 4'h1;
        mem_ready = 1'b1;
        #1 chk("R10 head before both", mem_addr, 32'h400);
        @(posedge clk);
        #1 st_valid = 1'b0; mem_ready = 1'b0;
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qb.pop_front());
        qa.push_back(32'h500); qd.push_back(32'h5050); qb.push_back(4'h1);
        chk("R10 not empty", empty, 0);
        chk("R10 not full", full, 0);
        take();
        #1 chk("R10 empty after drain", empty, 1);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_fill_stall();
        t_full_both();
        t_forward();
        t_same_cycle();
        finish_run();
    end
endmodule